// File: doc/BRIEF.md
# Prioritised Interrupt Acknowledge Unit

This block sits beside a processor core and decides which pending interrupt the core services next. It has three sources. The first is an edge-triggered non-maskable input. The second is a pulse from the core for software traps and internal faults, which carries its own type number. The third is a level-sensitive maskable request from an external device. The non-maskable source always wins. A software or fault request comes next. A maskable request is taken only when the core's interrupt-enable flag is set and the bus-lock input is low.

A maskable request starts a handshake with the device. The block drives two separate active-low acknowledge pulses with a parameterised gap between them. During the last cycle of the second pulse it captures the 8-bit type from the low data lines. The data present during the first pulse is ignored. Non-maskable and software requests need no handshake: the non-maskable source uses the fixed type 2, and a software request uses the type supplied with it.

For every source the block then raises a one-cycle take pulse to the core. At the same time it presents the type and the byte address of that type's 4-byte entry in the 1 KB pointer table, which is the type shifted left by two bits. The block also grants external bus-hold requests, but only while the lock input is low.

The sequencer states are as follows:
- ST_IDLE: waiting and arbitrating.
- ST_ACK1: first acknowledge pulse.
- ST_GAP: acknowledge high between the two pulses.
- ST_ACK2: second acknowledge pulse, when the type is captured.
- ST_TAKE: one cycle in which the take pulse is driven.

The transitions are as follows:
- ST_IDLE goes to ST_TAKE on a non-maskable or software grant.
- ST_IDLE goes to ST_ACK1 on a maskable grant.
- ST_ACK1 goes to ST_GAP after ACK_LEN cycles.
- ST_GAP goes to ST_ACK2 after GAP_LEN cycles.
- ST_ACK2 goes to ST_TAKE after ACK_LEN cycles.
- ST_TAKE always returns to ST_IDLE.

Arbitration happens only in ST_IDLE. A sequence that has started always completes.

Top module: `int_ack_unit`

## Requirements
- R1: When a non-maskable request is pending in idle, it is taken before any other source, with type 2 and table address 8, and without any acknowledge pulse.
- R2: A maskable request (intr_in high) is ignored while if_flag is 0: no acknowledge pulse and no take.
- R3: A maskable grant drives inta_n low for ACK_LEN cycles, then high for GAP_LEN cycles, then low for ACK_LEN cycles. The type is data_lo as sampled in the last low cycle of the second pulse. Data present during the first pulse has no effect.
- R4: take is high for exactly one cycle per serviced interrupt. irq_type and vec_addr are valid while take is high and hold their value until the next take.
- R5: While lock_in is 1, maskable requests are held off and hold_ack stays 0.
- R6: vec_addr equals irq_type multiplied by 4 (10 bits) for every type from 0 to 255. Type 0 gives 0x000 and type 255 gives 0x3FC.
- R7: The non-maskable input is edge-sensitive and latched. A one-cycle pulse is serviced exactly once, and a level held high is serviced once.
- R8: A software or fault request is a one-cycle pulse on soft_req with its type on soft_type. It is latched and then taken with that type and no acknowledge pulse. It ranks below a non-maskable request and above a maskable one.
- R9: With lock_in low, hold_ack equals hold_req delayed by one clock.
- R10: During and directly after reset, inta_n is 1, take is 0, irq_type and vec_addr are 0, and hold_ack is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| nmi_in | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_in | input | 1 | Maskable request, level sensitive |
| if_flag | input | 1 | Interrupt-enable flag from the core |
| lock_in | input | 1 | Bus lock: holds off maskable requests and bus-hold grants |
| soft_req | input | 1 | One-cycle software or fault interrupt request |
| soft_type | input | 8 | Type number that goes with soft_req |
| data_lo | input | 8 | Low data lines, carrying the device's type in the second acknowledge pulse |
| hold_req | input | 1 | External bus-hold request |
| inta_n | output | 1 | Interrupt acknowledge strobe, active low |
| take | output | 1 | One-cycle pulse telling the core to service irq_type |
| irq_type | output | 8 | Selected interrupt type |
| vec_addr | output | 10 | Byte address of the type's pointer table entry |
| hold_ack | output | 1 | Bus-hold grant |

## Verification
The bench builds the block with ACK_LEN = 3 and GAP_LEN = 2 instead of the defaults of 2 and 1. This makes the pulse widths and the gap distinguishable, so an off-by-one in either counter shows up as a wrong low-cycle count or a merged pulse. Different data bytes are driven during the first and second pulses, which shows which one is captured. Simultaneous non-maskable, software and maskable requests show the order of service. The extreme types 0 and 255 cover the table-address boundaries.

// File: rtl/iack_pkg.sv
package iack_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACK1,
        ST_GAP,
        ST_ACK2,
        ST_TAKE
    } iack_state_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_NMI,
        SRC_SOFT,
        SRC_MASK
    } iack_src_t;
endpackage

// File: rtl/iack_pend_latch.sv
module iack_pend_latch #(
    parameter int TYPE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nmi_in,
    input  logic              soft_req,
    input  logic [TYPE_W-1:0] soft_type,
    input  logic              clr_nmi,
    input  logic              clr_soft,
    output logic              nmi_pend,
    output logic              soft_pend,
    output logic [TYPE_W-1:0] soft_type_q
);
    logic nmi_prev;
    logic nmi_edge;

    assign nmi_edge = nmi_in & ~nmi_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_prev    <= 1'b0;
            nmi_pend    <= 1'b0;
            soft_pend   <= 1'b0;
            soft_type_q <= '0;
        end else begin
            nmi_prev <= nmi_in;
            // a new edge wins over a clear in the same cycle
            if (nmi_edge)
                nmi_pend <= 1'b1;
            else if (clr_nmi)
                nmi_pend <= 1'b0;
            if (soft_req) begin
                soft_pend   <= 1'b1;
                soft_type_q <= soft_type;
            end else if (clr_soft) begin
                soft_pend <= 1'b0;
            end
        end
    end

    assert_nmi_edge_latched_R7: assert property (@(posedge clk) disable iff (rst)
        (nmi_in && !nmi_prev) |=> nmi_pend);

    assert_soft_latched_R8: assert property (@(posedge clk) disable iff (rst)
        soft_req |=> (soft_pend && soft_type_q == $past(soft_type)));
endmodule

// File: rtl/iack_arbiter.sv
module iack_arbiter
    import iack_pkg::*;
(
    input  logic      nmi_pend,
    input  logic      soft_pend,
    input  logic      intr_in,
    input  logic      if_flag,
    input  logic      lock_in,
    output iack_src_t grant
);
    logic mask_ok;

    assign mask_ok = intr_in & if_flag & ~lock_in;

    always_comb begin
        grant = SRC_NONE;
        if (nmi_pend)
            grant = SRC_NMI;
        else if (soft_pend)
            grant = SRC_SOFT;
        else if (mask_ok)
            grant = SRC_MASK;
    end
endmodule

// File: rtl/iack_seq.sv
module iack_seq
    import iack_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int ACK_LEN  = 2,
    parameter int GAP_LEN  = 1,
    parameter int NMI_TYPE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  iack_src_t         grant,
    input  logic [TYPE_W-1:0] soft_type_q,
    input  logic [TYPE_W-1:0] data_lo,
    output logic              inta_n,
    output logic              take,
    output logic              clr_nmi,
    output logic              clr_soft,
    output logic              load,
    output logic [TYPE_W-1:0] type_nxt,
    output iack_state_t       state_o
);
    localparam int MAXL  = (ACK_LEN > GAP_LEN) ? ACK_LEN : GAP_LEN;
    localparam int CNT_W = $clog2(MAXL + 1);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_LEN - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_LEN - 1);

    iack_state_t      state, state_d;
    iack_src_t        src_q, src_d;
    logic [CNT_W-1:0] cnt, cnt_d;

    // next-state and counter
    always_comb begin
        state_d = state;
        src_d   = src_q;
        cnt_d   = cnt;
        unique case (state)
            ST_IDLE: begin
                cnt_d = '0;
                unique case (grant)
                    SRC_NMI, SRC_SOFT: begin
                        state_d = ST_TAKE;
                        src_d   = grant;
                    end
                    SRC_MASK: begin
                        state_d = ST_ACK1;
                        src_d   = SRC_MASK;
                    end
                    default: ;
                endcase
            end
            ST_ACK1: begin
                if (cnt == ACK_LAST) begin
                    state_d = ST_GAP;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            ST_GAP: begin
                if (cnt == GAP_LAST) begin
                    state_d = ST_ACK2;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            ST_ACK2: begin
                if (cnt == ACK_LAST) begin
                    state_d = ST_TAKE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt + 1'b1;
                end
            end
            ST_TAKE: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            src_q <= SRC_NONE;
            cnt   <= '0;
        end else begin
            state <= state_d;
            src_q <= src_d;
            cnt   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        inta_n   = 1'b1;
        take     = 1'b0;
        clr_nmi  = 1'b0;
        clr_soft = 1'b0;
        load     = 1'b0;
        type_nxt = '0;
        unique case (state)
            ST_IDLE: begin
                if (grant == SRC_NMI) begin
                    clr_nmi  = 1'b1;
                    load     = 1'b1;
                    type_nxt = TYPE_W'(NMI_TYPE);
                end else if (grant == SRC_SOFT) begin
                    clr_soft = 1'b1;
                    load     = 1'b1;
                    type_nxt = soft_type_q;
                end
            end
            ST_ACK1: inta_n = 1'b0;
            ST_GAP:  inta_n = 1'b1;
            ST_ACK2: begin
                inta_n = 1'b0;
                if (cnt == ACK_LAST) begin
                    load     = 1'b1;
                    type_nxt = data_lo;
                end
            end
            ST_TAKE: take = 1'b1;
            default: ;
        endcase
    end

    assign state_o = state;

    assert_take_single_R4: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);

    assert_mask_via_ack2_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TAKE && src_q == SRC_MASK) |-> $past(state) == ST_ACK2);

    assert_gap_between_pulses_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ACK1 && cnt == ACK_LAST) |=> (state == ST_GAP && inta_n));
endmodule

// File: rtl/iack_vector.sv
module iack_vector #(
    parameter int TYPE_W = 8,
    parameter int SHIFT  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [TYPE_W-1:0]       type_nxt,
    output logic [TYPE_W-1:0]       type_q,
    output logic [TYPE_W+SHIFT-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            type_q <= '0;
            addr_q <= '0;
        end else if (load) begin
            type_q <= type_nxt;
            addr_q <= {type_nxt, {SHIFT{1'b0}}};
        end
    end

    assert_hold_between_loads_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(type_q) && $stable(addr_q)));
endmodule

// File: rtl/int_ack_unit.sv
module int_ack_unit
    import iack_pkg::*;
#(
    parameter int TYPE_W   = 8,
    parameter int ACK_LEN  = 2,
    parameter int GAP_LEN  = 1,
    parameter int NMI_TYPE = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                nmi_in,
    input  logic                intr_in,
    input  logic                if_flag,
    input  logic                lock_in,
    input  logic                soft_req,
    input  logic [TYPE_W-1:0]   soft_type,
    input  logic [TYPE_W-1:0]   data_lo,
    input  logic                hold_req,
    output logic                inta_n,
    output logic                take,
    output logic [TYPE_W-1:0]   irq_type,
    output logic [TYPE_W+1:0]   vec_addr,
    output logic                hold_ack
);
    localparam int SHIFT = 2;

    logic              nmi_pend, soft_pend, clr_nmi, clr_soft, load;
    logic [TYPE_W-1:0] soft_type_q, type_nxt;
    iack_src_t         grant;
    iack_state_t       st;

    iack_pend_latch #(.TYPE_W(TYPE_W)) u_pend (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .soft_req(soft_req),
        .soft_type(soft_type), .clr_nmi(clr_nmi), .clr_soft(clr_soft),
        .nmi_pend(nmi_pend), .soft_pend(soft_pend), .soft_type_q(soft_type_q)
    );

    iack_arbiter u_arb (
        .nmi_pend(nmi_pend), .soft_pend(soft_pend), .intr_in(intr_in),
        .if_flag(if_flag), .lock_in(lock_in), .grant(grant)
    );

    iack_seq #(
        .TYPE_W(TYPE_W), .ACK_LEN(ACK_LEN), .GAP_LEN(GAP_LEN), .NMI_TYPE(NMI_TYPE)
    ) u_seq (
        .clk(clk), .rst(rst), .grant(grant), .soft_type_q(soft_type_q),
        .data_lo(data_lo), .inta_n(inta_n), .take(take), .clr_nmi(clr_nmi),
        .clr_soft(clr_soft), .load(load), .type_nxt(type_nxt), .state_o(st)
    );

    iack_vector #(.TYPE_W(TYPE_W), .SHIFT(SHIFT)) u_vec (
        .clk(clk), .rst(rst), .load(load), .type_nxt(type_nxt),
        .type_q(irq_type), .addr_q(vec_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            hold_ack <= 1'b0;
        else
            hold_ack <= hold_req & ~lock_in;
    end

    assert_nmi_first_R1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && nmi_pend) |=> (take && irq_type == TYPE_W'(NMI_TYPE)));

    assert_if_gates_mask_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !if_flag) |=> st != ST_ACK1);

    assert_lock_gates_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && lock_in) |=> st != ST_ACK1);

    assert_lock_blocks_hold_R5: assert property (@(posedge clk) disable iff (rst)
        lock_in |=> !hold_ack);

    assert_addr_matches_type_R6: assert property (@(posedge clk) disable iff (rst)
        take |-> vec_addr == {irq_type, 2'b00});
endmodule

// File: tb/tb_int_ack_unit.sv
module tb_int_ack_unit;
    localparam int ACK_LEN = 3;
    localparam int GAP_LEN = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       nmi_in = 1'b0, intr_in = 1'b0, if_flag = 1'b0, lock_in = 1'b0;
    logic       soft_req = 1'b0, hold_req = 1'b0;
    logic [7:0] soft_type = 8'h00, data_lo = 8'h00;
    logic       inta_n, take, hold_ack;
    logic [7:0] irq_type;
    logic [9:0] vec_addr;

    int tests = 0, fails = 0, cyc = 0;
    int falls = 0, lows = 0, takes = 0;
    logic inta_prev = 1'b1;
    logic [7:0] ack_data = 8'h00;
    logic [7:0] take_log [8];

    int_ack_unit #(.ACK_LEN(ACK_LEN), .GAP_LEN(GAP_LEN)) dut (
        .clk(clk), .rst(rst), .nmi_in(nmi_in), .intr_in(intr_in),
        .if_flag(if_flag), .lock_in(lock_in), .soft_req(soft_req),
        .soft_type(soft_type), .data_lo(data_lo), .hold_req(hold_req),
        .inta_n(inta_n), .take(take), .irq_type(irq_type),
        .vec_addr(vec_addr), .hold_ack(hold_ack)
    );

    always #10 clk = ~clk;

    // bus-side monitor and device model, at the falling edge
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst) begin
            if (!inta_n) begin
                lows = lows + 1;
                if (inta_prev) falls = falls + 1;
                data_lo = falls[0] ? 8'hEE : ack_data;
            end
            inta_prev = inta_n;
            if (take) begin
                take_log[takes % 8] = irq_type;
                takes = takes + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #5;
        end
    endtask

    task automatic clear_mon();
        falls = 0; lows = 0; takes = 0;
    endtask

    task automatic wait_take(input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit && !seen; i++) begin
            tick();
            if (take) seen = 1'b1;
        end
    endtask

    task automatic t_reset();
        check(inta_n == 1'b1, "R10 inta_n", inta_n, 1);
        check(take == 1'b0, "R10 take", take, 0);
        check(irq_type == 8'h00 && vec_addr == 10'h000, "R10 type/addr", vec_addr, 0);
        check(hold_ack == 1'b0, "R10 hold_ack", hold_ack, 0);
    endtask

    task automatic t_nmi_pulse();
        bit seen;
        clear_mon();
        nmi_in = 1'b1; tick(); nmi_in = 1'b0;
        wait_take(10, seen);
        check(seen, "R1 nmi taken", seen, 1);
        check(irq_type == 8'd2, "R1 nmi type", irq_type, 2);
        check(vec_addr == 10'd8, "R1 nmi addr", vec_addr, 8);
        check(falls == 0, "R1 nmi no ack pulse", falls, 0);
        tick();
        check(take == 1'b0, "R4 take one cycle", take, 0);
        tick(10);
        check(takes == 1, "R7 single pulse serviced once", takes, 1);
    endtask

    task automatic t_nmi_level();
        clear_mon();
        nmi_in = 1'b1; tick(20); nmi_in = 1'b0; tick(5);
        check(takes == 1, "R7 level serviced once", takes, 1);
    endtask

    task automatic t_intr();
        bit seen;
        clear_mon();
        ack_data = 8'h5A; if_flag = 1'b1; intr_in = 1'b1;
        wait_take(40, seen);
        intr_in = 1'b0;
        check(seen, "R3 maskable taken", seen, 1);
        check(falls == 2, "R3 two ack pulses", falls, 2);
        check(lows == 2 * ACK_LEN, "R3 ack low cycles", lows, 2 * ACK_LEN);
        check(irq_type == 8'h5A, "R3 type from second pulse", irq_type, 8'h5A);
        check(vec_addr == 10'h168, "R6 addr of 5A", vec_addr, 10'h168);
        tick(6);
        check(takes == 1, "R4 one take", takes, 1);
        check(irq_type == 8'h5A && vec_addr == 10'h168, "R4 type held", irq_type, 8'h5A);
    endtask

    task automatic t_gap();
        // measure the high gap between the two pulses
        int gap = 0;
        int low_seen = 0;
        bit in_gap = 1'b0;
        bit done = 1'b0;
        ack_data = 8'h11; if_flag = 1'b1; intr_in = 1'b1;
        for (int i = 0; i < 40 && !done; i++) begin
            tick();
            if (!inta_n) begin
                if (in_gap) done = 1'b1;
                low_seen = 1;
            end else if (low_seen == 1) begin
                in_gap = 1'b1;
                gap = gap + 1;
            end
            if (take) intr_in = 1'b0;
        end
        check(gap == GAP_LEN, "R3 gap length", gap, GAP_LEN);
        for (int i = 0; i < 20 && intr_in; i++) begin
            tick();
            if (take) intr_in = 1'b0;
        end
        tick(3);
    endtask

    task automatic t_masked();
        clear_mon();
        if_flag = 1'b0; intr_in = 1'b1; tick(15); intr_in = 1'b0;
        check(takes == 0 && falls == 0, "R2 masked ignored", takes + falls, 0);
        check(inta_n == 1'b1, "R2 inta idle", inta_n, 1);
    endtask

    task automatic t_lock();
        bit seen;
        clear_mon();
        ack_data = 8'h33; if_flag = 1'b1; lock_in = 1'b1; hold_req = 1'b1; intr_in = 1'b1;
        tick(12);
        check(takes == 0 && falls == 0, "R5 lock holds off maskable", takes + falls, 0);
        check(hold_ack == 1'b0, "R5 hold refused under lock", hold_ack, 0);
        lock_in = 1'b0; tick();
        check(hold_ack == 1'b1, "R9 hold granted", hold_ack, 1);
        hold_req = 1'b0; tick();
        check(hold_ack == 1'b0, "R9 hold released", hold_ack, 0);
        wait_take(40, seen);
        intr_in = 1'b0;
        check(seen && irq_type == 8'h33, "R5 maskable after unlock", irq_type, 8'h33);
        tick(3);
    endtask

    task automatic t_soft(input logic [7:0] ty, input logic [9:0] exp_addr);
        bit seen;
        clear_mon();
        soft_type = ty; soft_req = 1'b1; tick(); soft_req = 1'b0; soft_type = 8'h00;
        wait_take(10, seen);
        check(seen && irq_type == ty, "R8 soft type", irq_type, ty);
        check(vec_addr == exp_addr, "R6 soft addr", vec_addr, exp_addr);
        check(falls == 0, "R8 soft no ack", falls, 0);
        tick(3);
    endtask

    task automatic t_prio();
        bit seen;
        clear_mon();
        ack_data = 8'h77; if_flag = 1'b1;
        nmi_in = 1'b1; soft_type = 8'h40; soft_req = 1'b1;
        tick();
        nmi_in = 1'b0; soft_req = 1'b0; intr_in = 1'b1;
        for (int k = 0; k < 3; k++) begin
            wait_take(40, seen);
        end
        intr_in = 1'b0;
        tick(3);
        check(takes == 3, "R1 three services", takes, 3);
        check(take_log[0] == 8'd2, "R1 nmi first", take_log[0], 2);
        check(take_log[1] == 8'h40, "R8 soft second", take_log[1], 8'h40);
        check(take_log[2] == 8'h77, "R8 maskable last", take_log[2], 8'h77);
    endtask

    initial begin
        tick(3);
        t_reset();
        rst = 1'b0;
        tick();
        t_reset();
        t_nmi_pulse();
        t_nmi_level();
        t_intr();
        t_gap();
        t_masked();
        t_lock();
        t_soft(8'hFF, 10'h3FC);
        t_soft(8'h00, 10'h000);
        t_prio();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        tests = tests + 1;
        fails = fails + 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule